// File: doc/BRIEF.md
# Escalating Watchdog Channel

This block is a single watchdog channel controlled through a small register bus. It does not count time itself. It takes a set of expiry pulses from several general-purpose timers and follows one of them, chosen by a field in its configuration register. Each expiry of the followed timer moves the channel one stage further along. The first unserviced expiry raises a pending flag and, if enabled, the interrupt line. When four expiries have arrived since the last service, the channel pulses its reset-request outputs.

Software arms the channel with a start command and services it by writing the same start command again. That write clears the stage count and the pending flag. The followed timer should therefore run at a quarter of the intended watchdog period. Stopping the channel is guarded: a stop command only takes effect if the unlock key was written first. Every stop attempt uses up the unlock, whether or not it succeeds.

Top module: `wdog_channel`

## Requirements
- R1: After reset the channel is stopped with a stage count of zero. The configuration (offset 0x0) and status (offset 0x4) registers read zero. `irq_o`, `sys_rst_req_o` and `ctl_rst_req_o` are all low.
- R2: The configuration register at offset 0x0 holds the source select in bits [3:0], the count enable in bit 4, the interrupt enable in bit 12, the system-reset enable in bit 14 and the controller-reset enable in bit 15. All other bits read back as zero.
- R3: The timer followed is the one named by the source select at the time of the last start command. Later changes to the field take effect only at the next start. A select of `NUM_TIMERS` or above produces no ticks.
- R4: The first counted expiry after a start sets status bit 1 (offset 0x4). `irq_o` equals status bit 1 ANDed with the interrupt enable.
- R5: The fourth counted expiry since the last start pulses `sys_rst_req_o` for one cycle if the system-reset enable is set. It pulses `ctl_rst_req_o` for one cycle if the controller-reset enable is set. Each output depends only on its own enable.
- R6: Writing bit 0 of the command register (offset 0x8) starts the channel. It clears the stage count and status bit 1, which is how software services the watchdog.
- R7: Writing bit 1 of the command register stops the channel, clearing the stage count and status bit 1. This happens only if the last write to the unlock register (offset 0xC) was exactly 0x0000C45A and no stop attempt has been made since that write. Otherwise the stop is ignored. A stop attempt takes priority over a start bit in the same write.
- R8: Expiries are counted only while the channel is running and the count enable (bit 4) is set.
- R9: After the fourth expiry the stage count wraps to zero and the channel keeps running. Four more unserviced expiries request reset again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| tmr_expiry | input | NUM_TIMERS | One expiry pulse per general-purpose timer |
| irq_o | output | 1 | Watchdog interrupt, level |
| sys_rst_req_o | output | 1 | System reset request, one-cycle pulse |
| ctl_rst_req_o | output | 1 | Clock/reset-controller reset request, one-cycle pulse |

## Verification
The bench targets the points where an escalation design usually breaks:
- **Fourth-expiry boundary.** A counter off by one would request reset on the third or fifth expiry.
- **Independent reset gating.** Gating both reset outputs with a shared enable would raise the system request when only the controller request is enabled.
- **Source select.** A design that follows the live select field, instead of the value latched at start, would count a newly selected timer before the next start. A design without bounds on the select would take ticks from a nonexistent timer.
- **Unlock rules.** The bench stops without the key, after a wrong key, and a second time on a used key. A design that keeps the unlock after a stop attempt, or accepts a partial key, would stop when it should keep running.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 4;
    localparam int SRC_W  = 4;

    localparam logic [ADDR_W-1:0] OFF_CFG  = 4'h0;
    localparam logic [ADDR_W-1:0] OFF_STAT = 4'h4;
    localparam logic [ADDR_W-1:0] OFF_CMD  = 4'h8;
    localparam logic [ADDR_W-1:0] OFF_KEY  = 4'hC;

    localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'h0000_C45A;

    localparam int CFG_PER_BIT   = 4;
    localparam int CFG_IRQ_BIT   = 12;
    localparam int CFG_SYS_BIT   = 14;
    localparam int CFG_CTL_BIT   = 15;
    localparam int STAT_PEND_BIT = 1;
    localparam int CMD_GO_BIT    = 0;
    localparam int CMD_HALT_BIT  = 1;

    typedef struct packed {
        logic             ctl_rst_en;
        logic             sys_rst_en;
        logic             irq_en;
        logic             per_en;
        logic [SRC_W-1:0] src;
    } cfg_t;

endpackage

// File: rtl/wdog_regfile.sv
module wdog_regfile
    import wdog_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr_en,
    input  logic              stat_pend,
    output cfg_t              cfg_o,
    output logic              go_o,
    output logic              halt_o,
    output logic [DATA_W-1:0] rdata
);

    typedef struct packed {
        cfg_t cfg;
        logic armed;
    } rf_state_t;

    rf_state_t s_d, s_q;
    logic cfg_wr, cmd_wr, key_wr;

    always_comb begin
        cfg_wr = wr_en && (addr == OFF_CFG);
        cmd_wr = wr_en && (addr == OFF_CMD);
        key_wr = wr_en && (addr == OFF_KEY);
        s_d    = s_q;
        go_o   = 1'b0;
        halt_o = 1'b0;

        if (cfg_wr) begin
            s_d.cfg.src        = wdata[SRC_W-1:0];
            s_d.cfg.per_en     = wdata[CFG_PER_BIT];
            s_d.cfg.irq_en     = wdata[CFG_IRQ_BIT];
            s_d.cfg.sys_rst_en = wdata[CFG_SYS_BIT];
            s_d.cfg.ctl_rst_en = wdata[CFG_CTL_BIT];
        end

        // A halt attempt always consumes the unlock; it only acts if armed.
        if (cmd_wr && wdata[CMD_HALT_BIT]) begin
            halt_o    = s_q.armed;
            s_d.armed = 1'b0;
        end else if (cmd_wr && wdata[CMD_GO_BIT]) begin
            go_o = 1'b1;
        end

        if (key_wr) begin
            s_d.armed = (wdata == UNLOCK_KEY);
        end

        rdata = '0;
        case (addr)
            OFF_CFG: begin
                rdata[SRC_W-1:0]  = s_q.cfg.src;
                rdata[CFG_PER_BIT] = s_q.cfg.per_en;
                rdata[CFG_IRQ_BIT] = s_q.cfg.irq_en;
                rdata[CFG_SYS_BIT] = s_q.cfg.sys_rst_en;
                rdata[CFG_CTL_BIT] = s_q.cfg.ctl_rst_en;
            end
            OFF_STAT: rdata[STAT_PEND_BIT] = stat_pend;
            default:  rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cfg_o = s_q.cfg;

endmodule

// File: rtl/wdog_tick_mux.sv
module wdog_tick_mux #(
    parameter int NUM_TIMERS = 10,
    parameter int SEL_W      = 4
) (
    input  logic [NUM_TIMERS-1:0] expiry,
    input  logic [SEL_W-1:0]      sel,
    output logic                  tick
);

    logic [NUM_TIMERS-1:0] hit;

    // Selects beyond the last timer match no lane and so give no tick.
    generate
        for (genvar g = 0; g < NUM_TIMERS; g++) begin : g_lane
            assign hit[g] = expiry[g] && (sel == SEL_W'(g));
        end
    endgenerate

    assign tick = |hit;

endmodule

// File: rtl/wdog_stage_ctr.sv
module wdog_stage_ctr #(
    parameter int NUM_STAGES = 4,
    parameter int SRC_W      = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go_i,
    input  logic             halt_i,
    input  logic             per_en_i,
    input  logic             sys_en_i,
    input  logic             ctl_en_i,
    input  logic [SRC_W-1:0] src_cfg_i,
    input  logic             tick_i,
    output logic [SRC_W-1:0] src_o,
    output logic             pend_o,
    output logic             sys_rst_o,
    output logic             ctl_rst_o
);

    localparam int STG_W = (NUM_STAGES > 1) ? $clog2(NUM_STAGES) : 1;
    localparam int LAST  = NUM_STAGES - 1;

    typedef struct packed {
        logic             run;
        logic [STG_W-1:0] stage;
        logic             pend;
        logic [SRC_W-1:0] src;
        logic             sys;
        logic             ctl;
    } ctr_state_t;

    ctr_state_t c_d, c_q;

    always_comb begin
        c_d     = c_q;
        c_d.sys = 1'b0;
        c_d.ctl = 1'b0;
        if (halt_i) begin
            c_d.run   = 1'b0;
            c_d.stage = '0;
            c_d.pend  = 1'b0;
        end else if (go_i) begin
            c_d.run   = 1'b1;
            c_d.stage = '0;
            c_d.pend  = 1'b0;
            c_d.src   = src_cfg_i;
        end else if (c_q.run && per_en_i && tick_i) begin
            if (c_q.stage == '0) begin
                c_d.pend = 1'b1;
            end
            if (c_q.stage == STG_W'(LAST)) begin
                c_d.sys   = sys_en_i;
                c_d.ctl   = ctl_en_i;
                c_d.stage = '0;
            end else begin
                c_d.stage = c_q.stage + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign src_o     = c_q.src;
    assign pend_o    = c_q.pend;
    assign sys_rst_o = c_q.sys;
    assign ctl_rst_o = c_q.ctl;

endmodule

// File: rtl/wdog_channel.sv
module wdog_channel
    import wdog_pkg::*;
#(
    parameter int NUM_TIMERS = 10,
    parameter int NUM_STAGES = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    input  logic                  bus_wr,
    output logic [DATA_W-1:0]     bus_rdata,
    input  logic [NUM_TIMERS-1:0] tmr_expiry,
    output logic                  irq_o,
    output logic                  sys_rst_req_o,
    output logic                  ctl_rst_req_o
);

    cfg_t             cfg_q;
    logic             go_s, halt_s, tick, pend;
    logic [SRC_W-1:0] src_act;

    wdog_regfile u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .wr_en     (bus_wr),
        .stat_pend (pend),
        .cfg_o     (cfg_q),
        .go_o      (go_s),
        .halt_o    (halt_s),
        .rdata     (bus_rdata)
    );

    wdog_tick_mux #(
        .NUM_TIMERS (NUM_TIMERS),
        .SEL_W      (SRC_W)
    ) u_mux (
        .expiry (tmr_expiry),
        .sel    (src_act),
        .tick   (tick)
    );

    wdog_stage_ctr #(
        .NUM_STAGES (NUM_STAGES),
        .SRC_W      (SRC_W)
    ) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .go_i      (go_s),
        .halt_i    (halt_s),
        .per_en_i  (cfg_q.per_en),
        .sys_en_i  (cfg_q.sys_rst_en),
        .ctl_en_i  (cfg_q.ctl_rst_en),
        .src_cfg_i (cfg_q.src),
        .tick_i    (tick),
        .src_o     (src_act),
        .pend_o    (pend),
        .sys_rst_o (sys_rst_req_o),
        .ctl_rst_o (ctl_rst_req_o)
    );

    assign irq_o = pend && cfg_q.irq_en;

endmodule

// File: rtl/wdog_channel_chk.sv
module wdog_channel_chk
    import wdog_pkg::*;
(
    input logic clk,
    input logic rst_n,
    input cfg_t cfg,
    input logic tick,
    input logic go_s,
    input logic halt_s,
    input logic pend,
    input logic sys_rst,
    input logic ctl_rst
);

    // R5: each reset request only with its own enable
    p_sys_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst |-> cfg.sys_rst_en);
    p_ctl_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rst |-> cfg.ctl_rst_en);
    // R5: a reset request follows a selected-timer tick and lasts one cycle
    p_sys_after_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst |-> $past(tick));
    p_sys_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst |=> !sys_rst);
    // R4: pending only rises on a tick
    p_pend_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend) |-> $past(tick));
    // R6: start clears the pending flag
    p_go_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        go_s |=> !pend);
    // R7: an accepted stop clears the pending flag
    p_halt_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        halt_s |=> !pend);

endmodule

bind wdog_channel wdog_channel_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg     (cfg_q),
    .tick    (tick),
    .go_s    (go_s),
    .halt_s  (halt_s),
    .pend    (pend),
    .sys_rst (sys_rst_req_o),
    .ctl_rst (ctl_rst_req_o)
);

// File: tb/tb_wdog_channel.sv
`timescale 1ns/100ps
module tb_wdog_channel;

    localparam int NT = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [3:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic          bus_wr = 1'b0;
    logic [31:0]   bus_rdata;
    logic [NT-1:0] tmr_expiry = '0;
    logic          irq_o, sys_rst_req_o, ctl_rst_req_o;

    int errors = 0;
    int checks = 0;
    int sys_cnt = 0;
    int ctl_cnt = 0;
    logic [31:0] rv;

    always #2.5 clk = ~clk;

    wdog_channel #(.NUM_TIMERS(NT), .NUM_STAGES(4)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rdata(bus_rdata), .tmr_expiry(tmr_expiry),
        .irq_o(irq_o), .sys_rst_req_o(sys_rst_req_o), .ctl_rst_req_o(ctl_rst_req_o)
    );

    // Behavioural reference model
    int          m_run, m_stage, m_pend, m_src, m_unlock, m_sys, m_ctl;
    logic [31:0] m_cfg;

    initial begin
        m_run = 0; m_stage = 0; m_pend = 0; m_src = 0;
        m_unlock = 0; m_sys = 0; m_ctl = 0; m_cfg = '0;
    end

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_run = 0; m_stage = 0; m_pend = 0; m_src = 0;
            m_unlock = 0; m_sys = 0; m_ctl = 0; m_cfg = '0;
        end else begin
            automatic logic [31:0] old_cfg = m_cfg;
            automatic bit tk = (m_run != 0) && old_cfg[4] &&
                               (int'(old_cfg[3:0]) == m_src) && (m_src < NT) &&
                               tmr_expiry[m_src % NT];
            automatic bit is_cmd = bus_wr && bus_addr == 4'h8;
            m_sys = 0; m_ctl = 0;
            if (bus_wr && bus_addr == 4'h0) m_cfg = bus_wdata & 32'h0000_D01F;
            if (is_cmd && bus_wdata[1]) begin
                if (m_unlock != 0) begin m_run = 0; m_stage = 0; m_pend = 0; end
                m_unlock = 0;
            end else if (is_cmd && bus_wdata[0]) begin
                m_run = 1; m_stage = 0; m_pend = 0; m_src = int'(old_cfg[3:0]);
            end else if ((m_run != 0) && old_cfg[4] && (m_src < NT) && tmr_expiry[m_src % NT]) begin
                if (m_stage == 0) m_pend = 1;
                if (m_stage == 3) begin
                    m_sys = int'(old_cfg[14]); m_ctl = int'(old_cfg[15]); m_stage = 0;
                end else m_stage = m_stage + 1;
            end
            if (tk) begin end
            if (bus_wr && bus_addr == 4'hC) m_unlock = (bus_wdata == 32'h0000_C45A) ? 1 : 0;
        end
    end

    function automatic logic [31:0] m_rdata(logic [3:0] a);
        if (a == 4'h0) return m_cfg;
        if (a == 4'h4) return m_pend ? 32'h2 : 32'h0;
        return 32'h0;
    endfunction

    always @(posedge clk) begin
        #2;
        checks++;
        if (irq_o !== (m_pend != 0 && m_cfg[12])) begin
            errors++;
            $display("FAIL R4 irq_o actual=%0b expected=%0b t=%0t", irq_o, (m_pend != 0 && m_cfg[12]), $time);
        end
        checks++;
        if (sys_rst_req_o !== (m_sys != 0) || ctl_rst_req_o !== (m_ctl != 0)) begin
            errors++;
            $display("FAIL R5 sys/ctl actual=%0b%0b expected=%0b%0b t=%0t",
                     sys_rst_req_o, ctl_rst_req_o, m_sys != 0, m_ctl != 0, $time);
        end
        checks++;
        if (bus_rdata !== m_rdata(bus_addr)) begin
            errors++;
            $display("FAIL R2 rdata actual=%h expected=%h t=%0t", bus_rdata, m_rdata(bus_addr), $time);
        end
        if (sys_rst_req_o === 1'b1) sys_cnt++;
        if (ctl_rst_req_o === 1'b1) ctl_cnt++;
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic pulse(int i);
        @(negedge clk);
        tmr_expiry = '0;
        tmr_expiry[i] = 1'b1;
        @(negedge clk);
        tmr_expiry = '0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        int s0, c0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(4'h0, rv); chk("R1 cfg", rv, 32'h0);
        rd(4'h4, rv); chk("R1 status", rv, 32'h0);
        chk("R1 outputs", {29'h0, irq_o, sys_rst_req_o, ctl_rst_req_o}, 32'h0);
        // R2 field mask
        wr(4'h0, 32'hFFFF_FFFF); rd(4'h0, rv); chk("R2 mask", rv, 32'h0000_D01F);
        wr(4'h0, 32'h0000_D012); rd(4'h0, rv); chk("R2 cfg", rv, 32'h0000_D012);
        // R3/R4 first expiry on selected timer only
        wr(4'h8, 32'h1);
        pulse(3); rd(4'h4, rv); chk("R3 other timer", rv, 32'h0);
        pulse(2); rd(4'h4, rv); chk("R4 status", rv, 32'h2);
        chk("R4 irq", {31'h0, irq_o}, 32'h1);
        // R6 ping
        wr(4'h8, 32'h1); rd(4'h4, rv); chk("R6 ping status", rv, 32'h0);
        chk("R6 ping irq", {31'h0, irq_o}, 32'h0);
        // R5 fourth expiry
        s0 = sys_cnt; c0 = ctl_cnt;
        repeat (3) pulse(2);
        repeat (2) @(negedge clk);
        chk("R5 no reset at third", sys_cnt - s0, 0);
        pulse(2);
        repeat (3) @(negedge clk);
        chk("R5 sys pulse", sys_cnt - s0, 1);
        chk("R5 ctl pulse", ctl_cnt - c0, 1);
        // R9 wrap and continue
        repeat (4) pulse(2);
        repeat (3) @(negedge clk);
        chk("R9 second reset", sys_cnt - s0, 2);
        // R5 gating: controller reset only
        wr(4'h0, 32'h0000_8012); wr(4'h8, 32'h1);
        s0 = sys_cnt; c0 = ctl_cnt;
        repeat (4) pulse(2);
        repeat (3) @(negedge clk);
        chk("R5 gated sys", sys_cnt - s0, 0);
        chk("R5 gated ctl", ctl_cnt - c0, 1);
        // R4 interrupt disabled
        wr(4'h0, 32'h0000_0012); wr(4'h8, 32'h1);
        pulse(2); rd(4'h4, rv); chk("R4 status no irq_en", rv, 32'h2);
        chk("R4 irq masked", {31'h0, irq_o}, 32'h0);
        // R8 count enable off
        wr(4'h0, 32'h0000_0002); wr(4'h8, 32'h1);
        pulse(2); rd(4'h4, rv); chk("R8 no count", rv, 32'h0);
        // R7 unlock rules
        wr(4'h0, 32'h0000_D012); wr(4'h8, 32'h1);
        wr(4'h8, 32'h2);
        pulse(2); rd(4'h4, rv); chk("R7 stop without key", rv, 32'h2);
        wr(4'h8, 32'h1);
        wr(4'hC, 32'h0000_C45A); wr(4'hC, 32'h0000_1234); wr(4'h8, 32'h2);
        pulse(2); rd(4'h4, rv); chk("R7 stop after wrong key", rv, 32'h2);
        wr(4'hC, 32'h0001_C45A); wr(4'h8, 32'h2);
        wr(4'h8, 32'h1);
        pulse(2); rd(4'h4, rv); chk("R7 partial key", rv, 32'h2);
        wr(4'hC, 32'h0000_C45A); wr(4'h8, 32'h2);
        rd(4'h4, rv); chk("R7 stop clears", rv, 32'h0);
        pulse(2); rd(4'h4, rv); chk("R7 stopped", rv, 32'h0);
        wr(4'h8, 32'h1); wr(4'h8, 32'h2);
        pulse(2); rd(4'h4, rv); chk("R7 key consumed", rv, 32'h2);
        // R3 select latched at start
        wr(4'h8, 32'h1); wr(4'h0, 32'h0000_D015);
        pulse(5); rd(4'h4, rv); chk("R3 new src before start", rv, 32'h0);
        pulse(2); rd(4'h4, rv); chk("R3 old src active", rv, 32'h2);
        wr(4'h8, 32'h1);
        pulse(2); rd(4'h4, rv); chk("R3 old src dropped", rv, 32'h0);
        pulse(5); rd(4'h4, rv); chk("R3 new src active", rv, 32'h2);
        // R3 out-of-range select
        wr(4'h0, 32'h0000_D01C); wr(4'h8, 32'h1);
        for (int i = 0; i < NT; i++) pulse(i);
        rd(4'h4, rv); chk("R3 out of range", rv, 32'h0);
        repeat (4) @(negedge clk);
        summary();
        $finish;
    end

endmodule